// File: doc/BRIEF.md
# Two-Step Shift and Rotate Unit

This unit carries out the register shift, rotate and byte-exchange operations of a small 16-bit processor. One request carries a 3-bit operation code, a step bit, a 2-bit register index, the 16-bit operand and the incoming carry (C) and overflow (OV) flags. The unit returns the new register value, new sign (S), zero (Z), C and OV flags, the number of machine cycles the operation takes, and the register index to write back.

A step bit of 0 moves the operand by one position. A step bit of 1 moves it by two positions. In the two-position rotate and carry forms, C and OV act as two extra bits above bit 15. The register file and instruction sequencing sit outside the unit.

While an operation executes, the unit raises an interrupt-block output for as many cycles as the operation costs. It accepts no new request during that window.

Top module: `shift_rotate_unit`

## Requirements
- R1: Op code 3'b000 exchanges the two bytes when the step bit is 0, and returns the operand unchanged (swapped twice) when the step bit is 1. S is result bit 7. C and OV pass through unchanged.
- R2: Op code 3'b001 shifts left by 1 or 2 with zero fill. S is result bit 15. C and OV pass through unchanged.
- R3: Op code 3'b010 rotates left through the flags. With step 0, the 17-bit chain {operand, C} is rotated and C receives bit 15. With step 1, the chain has C as bit 17 and OV as bit 16: the result is {operand[13:0], C, OV}, and C receives bit 15 while OV receives bit 14.
- R4: Op code 3'b011 shifts left with zero fill. Step 0 puts operand bit 15 into C. Step 1 puts bit 15 into C and bit 14 into OV. S is result bit 15.
- R5: Op code 3'b100 shifts right by 1 or 2 with zero fill. S is result bit 7. C and OV pass through unchanged.
- R6: Op code 3'b101 shifts right by 1 or 2, copying the sign bit into the vacated bits. S is result bit 7. C and OV pass through unchanged.
- R7: Op code 3'b110 rotates right through the flags. Step 0 gives {C, operand[15:1]}, and C receives bit 0. Step 1 gives {OV, C, operand[15:2]}, and C receives bit 0 while OV receives bit 1. S is result bit 7.
- R8: Op code 3'b111 is an arithmetic right shift into the flags. C receives operand bit 0. With step 1, OV also receives bit 1. S is result bit 7.
- R9: Z is 1 exactly when the 16-bit result is zero, for every operation.
- R10: The reported cycle count is 6 for step 0 and 8 for step 1.
- R11: A request is accepted on a clock edge only while irq_block is low. out_valid is then high for one cycle after that edge, and irq_block stays high for exactly the reported cycle count, starting in that same cycle. A request made while irq_block is high is ignored.
- R12: dst_sel echoes the register index of the accepted request. All result, flag, cycle and index outputs hold their value until the next accepted request. After reset, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request strobe |
| op | input | 3 | Operation code |
| two_step | input | 1 | 0: one position, 1: two positions |
| reg_sel | input | 2 | Register index 0 to 3 |
| src | input | 16 | Operand value |
| c_in | input | 1 | Incoming carry flag |
| ov_in | input | 1 | Incoming overflow flag |
| out_valid | output | 1 | One-cycle pulse when a new result is presented |
| dst_sel | output | 2 | Register index to write back |
| result | output | 16 | Result value |
| s_out | output | 1 | Sign flag |
| z_out | output | 1 | Zero flag |
| c_out | output | 1 | Carry flag |
| ov_out | output | 1 | Overflow flag |
| cycles | output | 4 | Machine cycle cost of the operation |
| irq_block | output | 1 | High while an operation executes; interrupts must wait |

## Verification
The bench builds the unit with its defaults: 16-bit width, a base cost of 6 cycles and a two-step surcharge of 2. At these values, the fixed sign positions at bits 7 and 15 and the 6/8 blocking windows match the instruction behaviour exactly.

A behavioural model predicts every output on every cycle. The stimulus covers all sixteen combinations of operation and step, with each C/OV pairing and with operands that hit zero results, sign extension and bytes that survive a swap. The bench also raises requests during the blocking window to confirm they are dropped.

// File: rtl/sru_pkg.sv
`timescale 1ns/1ps
package sru_pkg;
    typedef enum logic [2:0] {
        OP_SWAP = 3'b000,
        OP_SLL  = 3'b001,
        OP_RLC  = 3'b010,
        OP_SLLC = 3'b011,
        OP_SLR  = 3'b100,
        OP_SAR  = 3'b101,
        OP_RRC  = 3'b110,
        OP_SARC = 3'b111
    } sr_op_e;

    typedef struct packed {
        logic s;
        logic z;
        logic c;
        logic ov;
    } sr_flags_t;
endpackage

// File: rtl/sru_core.sv
`timescale 1ns/1ps
// Combinational datapath: computes the shifted value and the carry-chain flags.
module sru_core #(
    parameter int WIDTH = 16
) (
    input  sru_pkg::sr_op_e    op,
    input  logic               two_step,
    input  logic [WIDTH-1:0]   v,
    input  logic               c_i,
    input  logic               ov_i,
    output logic [WIDTH-1:0]   r,
    output logic               c_o,
    output logic               ov_o,
    output logic               s_from_low
);
    import sru_pkg::*;
    localparam int HALF = WIDTH / 2;

    logic [WIDTH-1:0] sar1, sar2, lsl1, lsl2, lsr1, lsr2;

    always_comb begin
        sar1 = {v[WIDTH-1], v[WIDTH-1:1]};
        sar2 = {{2{v[WIDTH-1]}}, v[WIDTH-1:2]};
        lsl1 = {v[WIDTH-2:0], 1'b0};
        lsl2 = {v[WIDTH-3:0], 2'b00};
        lsr1 = {1'b0, v[WIDTH-1:1]};
        lsr2 = {2'b00, v[WIDTH-1:2]};
    end

    always_comb begin
        r          = v;
        c_o        = c_i;
        ov_o       = ov_i;
        s_from_low = 1'b0;
        unique case (op)
            OP_SWAP: begin
                s_from_low = 1'b1;
                r = two_step ? v : {v[HALF-1:0], v[WIDTH-1:HALF]};
            end
            OP_SLL: r = two_step ? lsl2 : lsl1;
            OP_RLC: begin
                c_o = v[WIDTH-1];
                if (two_step) begin
                    r    = {v[WIDTH-3:0], c_i, ov_i};
                    ov_o = v[WIDTH-2];
                end else begin
                    r = {v[WIDTH-2:0], c_i};
                end
            end
            OP_SLLC: begin
                c_o = v[WIDTH-1];
                r   = two_step ? lsl2 : lsl1;
                if (two_step) ov_o = v[WIDTH-2];
            end
            OP_SLR: begin
                s_from_low = 1'b1;
                r = two_step ? lsr2 : lsr1;
            end
            OP_SAR: begin
                s_from_low = 1'b1;
                r = two_step ? sar2 : sar1;
            end
            OP_RRC: begin
                s_from_low = 1'b1;
                c_o = v[0];
                if (two_step) begin
                    r    = {ov_i, c_i, v[WIDTH-1:2]};
                    ov_o = v[1];
                end else begin
                    r = {c_i, v[WIDTH-1:1]};
                end
            end
            OP_SARC: begin
                s_from_low = 1'b1;
                c_o = v[0];
                r   = two_step ? sar2 : sar1;
                if (two_step) ov_o = v[1];
            end
            default: r = v;
        endcase
    end
endmodule

// File: rtl/sru_flags.sv
`timescale 1ns/1ps
// Sign and zero flag generation from the shifted value.
module sru_flags #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] r,
    input  logic             s_from_low,
    output logic             s,
    output logic             z
);
    localparam int LOW_SIGN = WIDTH / 2 - 1;

    always_comb begin
        s = s_from_low ? r[LOW_SIGN] : r[WIDTH-1];
        z = (r == '0);
    end
endmodule

// File: rtl/sru_timer.sv
`timescale 1ns/1ps
// Cycle cost and interrupt-block window.
module sru_timer #(
    parameter int BASE_CYC  = 6,
    parameter int EXTRA_CYC = 2,
    parameter int CNT_W     = $clog2(BASE_CYC + EXTRA_CYC + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             accept,
    input  logic             two_step,
    output logic [CNT_W-1:0] cost,
    output logic             hold
);
    localparam int MAX_CYC = BASE_CYC + EXTRA_CYC;

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cost  = two_step ? CNT_W'(MAX_CYC) : CNT_W'(BASE_CYC);
        cnt_d = cnt_q;
        if (accept)
            cnt_d = cost;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign hold = (cnt_q != '0);

    // R10
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_W'(MAX_CYC));

    // R11
    countdown_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/shift_rotate_unit.sv
`timescale 1ns/1ps
module shift_rotate_unit #(
    parameter int WIDTH     = 16,
    parameter int REG_W     = 2,
    parameter int BASE_CYC  = 6,
    parameter int EXTRA_CYC = 2,
    parameter int CNT_W     = $clog2(BASE_CYC + EXTRA_CYC + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [2:0]       op,
    input  logic             two_step,
    input  logic [REG_W-1:0] reg_sel,
    input  logic [WIDTH-1:0] src,
    input  logic             c_in,
    input  logic             ov_in,
    output logic             out_valid,
    output logic [REG_W-1:0] dst_sel,
    output logic [WIDTH-1:0] result,
    output logic             s_out,
    output logic             z_out,
    output logic             c_out,
    output logic             ov_out,
    output logic [CNT_W-1:0] cycles,
    output logic             irq_block
);
    import sru_pkg::*;

    typedef struct packed {
        logic             vld;
        logic [REG_W-1:0] dst;
        logic [WIDTH-1:0] res;
        sr_flags_t        flg;
        logic [CNT_W-1:0] cyc;
    } state_t;

    state_t           st_d, st_q;
    logic             accept;
    logic             hold;
    logic [CNT_W-1:0] cost;
    logic [WIDTH-1:0] core_r;
    logic             core_c, core_ov, core_low;
    logic             flag_s, flag_z;
    sr_op_e           op_e;

    assign op_e   = sr_op_e'(op);
    assign accept = in_valid && !hold;

    sru_core #(.WIDTH(WIDTH)) u_core (
        .op(op_e), .two_step(two_step), .v(src), .c_i(c_in), .ov_i(ov_in),
        .r(core_r), .c_o(core_c), .ov_o(core_ov), .s_from_low(core_low)
    );

    sru_flags #(.WIDTH(WIDTH)) u_flags (
        .r(core_r), .s_from_low(core_low), .s(flag_s), .z(flag_z)
    );

    sru_timer #(.BASE_CYC(BASE_CYC), .EXTRA_CYC(EXTRA_CYC), .CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst(rst), .accept(accept), .two_step(two_step),
        .cost(cost), .hold(hold)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        if (accept) begin
            st_d.vld    = 1'b1;
            st_d.dst    = reg_sel;
            st_d.res    = core_r;
            st_d.flg.s  = flag_s;
            st_d.flg.z  = flag_z;
            st_d.flg.c  = core_c;
            st_d.flg.ov = core_ov;
            st_d.cyc    = cost;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign dst_sel   = st_q.dst;
    assign result    = st_q.res;
    assign s_out     = st_q.flg.s;
    assign z_out     = st_q.flg.z;
    assign c_out     = st_q.flg.c;
    assign ov_out    = st_q.flg.ov;
    assign cycles    = st_q.cyc;
    assign irq_block = hold;

    // R11
    busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        irq_block |=> !out_valid);

    // R11
    valid_in_hold_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> irq_block);

    // R1
    swap_twice_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(op) == 3'b000 && $past(two_step)) |-> (result == $past(src)));

    // R2
    keep_flags_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(op) == 3'b001) |-> (c_out == $past(c_in) && ov_out == $past(ov_in)));

    // R9
    zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (z_out == (result == '0)));

    // R12
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> ($stable(result) && $stable(dst_sel) && $stable(cycles)));
endmodule

// File: tb/shift_rotate_unit_tb.sv
`timescale 1ns/1ps
module shift_rotate_unit_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [2:0]  op = 3'd0;
    logic        two_step = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [15:0] src = 16'd0;
    logic        c_in = 1'b0;
    logic        ov_in = 1'b0;
    logic        out_valid, s_out, z_out, c_out, ov_out, irq_block;
    logic [1:0]  dst_sel;
    logic [15:0] result;
    logic [3:0]  cycles;

    int checks = 0;
    int failures = 0;
    int cyc_count = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    shift_rotate_unit u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .two_step(two_step),
        .reg_sel(reg_sel), .src(src), .c_in(c_in), .ov_in(ov_in),
        .out_valid(out_valid), .dst_sel(dst_sel), .result(result),
        .s_out(s_out), .z_out(z_out), .c_out(c_out), .ov_out(ov_out),
        .cycles(cycles), .irq_block(irq_block)
    );

    // expected state
    logic        e_vld = 0, e_s = 0, e_z = 0, e_c = 0, e_ov = 0;
    logic [1:0]  e_dst = 0;
    logic [15:0] e_res = 0;
    int          e_cyc = 0;
    int          e_busy = 0;
    int          e_op = 0;

    function automatic string req_of(int o);
        string names[8] = '{"R1", "R2", "R3", "R4", "R5", "R6", "R7", "R8"};
        return names[o];
    endfunction

    task automatic model_op(input int o, input bit two, input logic [15:0] v,
                            input bit c, input bit ov);
        logic [16:0] x17;
        logic [17:0] x18;
        int n;
        n = two ? 2 : 1;
        e_c = c; e_ov = ov;
        case (o)
            0: e_res = two ? v : {v[7:0], v[15:8]};
            1: e_res = v << n;
            2: if (!two) begin x17 = {v, c}; e_res = x17[15:0]; e_c = x17[16]; end
               else begin x18 = {v, c, ov}; e_res = x18[15:0]; e_c = x18[17]; e_ov = x18[16]; end
            3: begin e_res = v << n; e_c = v[15]; if (two) e_ov = v[14]; end
            4: e_res = v >> n;
            5: e_res = 16'($signed(v) >>> n);
            6: if (!two) begin x17 = {c, v}; e_res = x17[16:1]; e_c = v[0]; end
               else begin x18 = {ov, c, v}; e_res = x18[17:2]; e_c = x18[0]; e_ov = x18[1]; end
            default: begin e_res = 16'($signed(v) >>> n); e_c = v[0]; if (two) e_ov = v[1]; end
        endcase
        e_s = (o == 0 || o >= 4) ? e_res[7] : e_res[15];
        e_z = (e_res == 16'd0);
        e_cyc = two ? 8 : 6;
    endtask

    always @(posedge clk) begin
        if (rst) begin
            e_vld <= 0; e_busy <= 0; e_res <= 0; e_s <= 0; e_z <= 0;
            e_c <= 0; e_ov <= 0; e_cyc <= 0; e_dst <= 0; e_op <= 0;
        end else if (e_busy == 0 && in_valid) begin
            model_op(int'(op), two_step, src, c_in, ov_in);
            e_vld  <= 1;
            e_dst  <= reg_sel;
            e_op   <= int'(op);
            e_busy <= two_step ? 8 : 6;
        end else begin
            e_vld <= 0;
            if (e_busy > 0) e_busy <= e_busy - 1;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !done) begin
            check(out_valid == e_vld, "R11", "out_valid", out_valid, e_vld);
            check(irq_block == (e_busy > 0), "R11", "irq_block", irq_block, e_busy > 0);
            check(result == e_res, req_of(e_op), "result", result, e_res);
            check(s_out == e_s, req_of(e_op), "S", s_out, e_s);
            check(c_out == e_c, req_of(e_op), "C", c_out, e_c);
            check(ov_out == e_ov, req_of(e_op), "OV", ov_out, e_ov);
            check(z_out == e_z, "R9", "Z", z_out, e_z);
            check(int'(cycles) == e_cyc, "R10", "cycles", cycles, e_cyc);
            check(dst_sel == e_dst, "R12", "dst_sel", dst_sel, e_dst);
        end
    end

    always @(posedge clk) begin
        cyc_count++;
        if (cyc_count > 150000 && !done) begin
            done = 1;
            checks++; failures++;
            $display("FAIL R11 watchdog actual=%0d expected=%0d", cyc_count, 150000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic issue(input int o, input bit two, input logic [15:0] v,
                         input bit c, input bit ov, input logic [1:0] rs);
        @(negedge clk);
        while (irq_block) @(negedge clk);
        in_valid = 1; op = 3'(o); two_step = two; src = v; c_in = c; ov_in = ov; reg_sel = rs;
        @(negedge clk);
        in_valid = 0;
        // R11: request during the blocking window must be dropped
        in_valid = 1; op = 3'(o ^ 1); src = ~v; reg_sel = ~rs;
        @(negedge clk);
        in_valid = 0;
    endtask

    initial begin
        logic [15:0] pats[6];
        pats = '{16'h0000, 16'h8001, 16'h00FF, 16'hC003, 16'h4000, 16'h1234};
        repeat (3) @(negedge clk);
        // R12: reset state
        check(out_valid == 0 && irq_block == 0 && result == 0 && cycles == 0,
              "R12", "reset outputs", result, 0);
        rst = 0;
        for (int o = 0; o < 8; o++)
            for (int t = 0; t < 2; t++)
                for (int p = 0; p < 6; p++)
                    issue(o, t[0], pats[p], p[0], p[1], 2'(o + p));
        for (int k = 0; k < 40; k++)
            issue(int'($urandom_range(7, 0)), 1'($urandom), 16'($urandom),
                  1'($urandom), 1'($urandom), 2'($urandom));
        // R3 and R7: two-step rotate with both flags set and a zero result path
        issue(2, 1, 16'h0000, 1, 1, 2'd3);
        issue(6, 1, 16'h0003, 0, 0, 2'd1);
        repeat (12) @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule